// File: doc/BRIEF.md
# Memory Page Decoder with Boot Remap

This block is the memory side of an 8-bit processor bus that has a 16-bit address. It looks at address bits 15:10 and produces four active-low 1 KB page selects: two ROM pages, one system RAM page and one display RAM page. It also produces an active-high memory-select flag. Inside the block are a 1K x 8 synchronous system RAM and a 2K x 8 ROM whose contents are computed at initialisation.

An active-low boot-remap input turns off decoding in the 0xC000 region. While it is low, the lowest 1 KB page (0x0000–0x03FF) maps onto the first ROM page, so that startup code can run from address zero. Read data is registered and appears one cycle after the address.

Top module: `page_mem_sys`

## Requirements
- R1: With remap_ni high and addr_i[15:12] = 4'hC, addr_i[11:10] selects the page. 00 asserts rom0_sel_no, 01 asserts rom1_sel_no, 10 asserts ram_sel_no and 11 asserts disp_sel_no.
- R2: With remap_ni high and addr_i[15:12] not equal to 4'hC, all four page selects are high (inactive).
- R3: Page selects are active low, and at most one of them is low in any cycle.
- R4: mem_sel_o is 1 exactly when one of the four page selects is low.
- R5: A write takes place only when wr_i is 1 and ram_sel_no is low. It stores wdata_i at word index addr_i[9:0]. A RAM read returns that word on rdata_o one clock after the address. A read and a write to the same word in the same cycle return the old contents.
- R6: Writes aimed at the ROM pages, at the display page, or at unselected addresses change neither the ROM nor the RAM.
- R7: With remap_ni low, addresses whose bits 15:10 are all zero assert rom0_sel_no, and every address in the 0xC000–0xCFFF region asserts no select.
- R8: With remap_ni high, addresses whose bits 15:10 are all zero assert no select, and mem_sel_o stays 0.
- R9: rdata_o is 8'h00 one clock after a cycle in which no page was selected or the display page was selected.
- R10: ROM byte at 11-bit index i equals ((i[7:0]*3) mod 256) XOR (i[10:8] << 5). The first ROM page, and page 0 under remap, read index {1'b0, addr_i[9:0]}. The second ROM page reads index {1'b1, addr_i[9:0]}.
- R11: While rst_ni is low, and in the first cycle after it rises, rdata_o is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| wr_i | input | 1 | Write strobe, active high |
| wdata_i | input | 8 | Write data |
| remap_ni | input | 1 | Boot remap, active low |
| rdata_o | output | 8 | Registered read data |
| rom0_sel_no | output | 1 | First ROM page select, active low |
| rom1_sel_no | output | 1 | Second ROM page select, active low |
| ram_sel_no | output | 1 | System RAM page select, active low |
| disp_sel_no | output | 1 | Display RAM page select, active low |
| mem_sel_o | output | 1 | Any page selected |

## Verification
The clocked properties assume that addr_i, wr_i and remap_ni are known and stable across each rising edge, so the combinational selects can be sampled there. They also assume that a change of remap_ni counts as an ordinary input change and needs no settling time. The bench drives every input only on the falling edge and keeps all of them at defined values from time zero. It varies remap_ni freely in the random phase, so the suppressed C-region and the remapped page 0 both show up under write strobes as well as reads.

// File: rtl/page_mem_pkg.sv
package page_mem_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned PAGE_W   = 10;
  localparam int unsigned RAM_DEPTH = 1 << PAGE_W;
  localparam int unsigned ROM_AW   = PAGE_W + 1;
  localparam int unsigned ROM_DEPTH = 1 << ROM_AW;
  localparam logic [3:0] REGION_NIB = 4'hC;

  typedef enum logic [2:0] {
    PG_NONE, PG_ROM0, PG_ROM1, PG_RAM, PG_DISP
  } page_e;

  function automatic logic [DATA_W-1:0] rom_byte(input logic [ROM_AW-1:0] idx);
    logic [DATA_W-1:0] lo;
    lo = idx[7:0];
    return DATA_W'(lo * 8'd3) ^ {idx[ROM_AW-1:8], 5'b0};
  endfunction
endpackage

// File: rtl/page_decode.sv
module page_decode
  import page_mem_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              remap_ni,
  output page_e             page_o
);
  logic [ADDR_W-PAGE_W-1:0] pg;
  assign pg = addr_i[ADDR_W-1:PAGE_W];

  always_comb begin
    page_o = PG_NONE;
    if (!remap_ni) begin
      // boot remap: low page becomes first ROM page, C region shut off
      if (pg == '0) page_o = PG_ROM0;
    end else if (addr_i[ADDR_W-1:ADDR_W-4] == REGION_NIB) begin
      unique case (addr_i[PAGE_W+1:PAGE_W])
        2'b00: page_o = PG_ROM0;
        2'b01: page_o = PG_ROM1;
        2'b10: page_o = PG_RAM;
        default: page_o = PG_DISP;
      endcase
    end
  end
endmodule

// File: rtl/sys_ram.sv
module sys_ram #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  // read-first
  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/boot_rom.sv
module boot_rom
  import page_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic [ROM_AW-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rom [ROM_DEPTH];

  initial begin
    for (int i = 0; i < ROM_DEPTH; i++) rom[i] = rom_byte(ROM_AW'(i));
  end

  always_ff @(posedge clk_i) rdata_o <= rom[addr_i];
endmodule

// File: rtl/page_mem_sys.sv
module page_mem_sys
  import page_mem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              remap_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rom0_sel_no,
  output logic              rom1_sel_no,
  output logic              ram_sel_no,
  output logic              disp_sel_no,
  output logic              mem_sel_o
);
  page_e page, page_q;
  logic [DATA_W-1:0] ram_q, rom_q;
  logic ram_we;

  page_decode u_dec (
    .addr_i  (addr_i),
    .remap_ni(remap_ni),
    .page_o  (page)
  );

  assign rom0_sel_no = (page != PG_ROM0);
  assign rom1_sel_no = (page != PG_ROM1);
  assign ram_sel_no  = (page != PG_RAM);
  assign disp_sel_no = (page != PG_DISP);
  assign mem_sel_o   = (page != PG_NONE);

  assign ram_we = wr_i && (page == PG_RAM);

  sys_ram #(.AW(PAGE_W), .DW(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .addr_i (addr_i[PAGE_W-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(ram_q)
  );

  boot_rom u_rom (
    .clk_i  (clk_i),
    .addr_i ({page == PG_ROM1, addr_i[PAGE_W-1:0]}),
    .rdata_o(rom_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_q <= PG_NONE;
    else         page_q <= page;
  end

  always_comb begin
    unique case (page_q)
      PG_ROM0, PG_ROM1: rdata_o = rom_q;
      PG_RAM:           rdata_o = ram_q;
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/page_mem_sys_chk.sv
module page_mem_sys_chk
  import page_mem_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              remap_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rom0_sel_no,
  input logic              rom1_sel_no,
  input logic              ram_sel_no,
  input logic              disp_sel_no,
  input logic              mem_sel_o
);
  logic [3:0] sels_n;
  assign sels_n = {rom0_sel_no, rom1_sel_no, ram_sel_no, disp_sel_no};

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~sels_n)); // R3
  AST_MEMSEL_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o == ($countones(~sels_n) == 1)); // R4
  AST_RAM_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_ni && addr_i[15:10] == 6'h32) |-> !ram_sel_no); // R1
  AST_BAD_NIBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_ni && addr_i[15:12] != 4'hC) |-> (sels_n == 4'hF)); // R2
  AST_REMAP_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!remap_ni && addr_i[15:12] == 4'hC) |-> (sels_n == 4'hF)); // R7
  AST_REMAP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!remap_ni && addr_i[15:10] == 6'h00) |-> !rom0_sel_no); // R7
  AST_PAGE0_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_ni && addr_i[15:10] == 6'h00) |-> !mem_sel_o); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom0_sel_no && rom1_sel_no && ram_sel_no) |=> (rdata_o == '0)); // R9
endmodule

bind page_mem_sys page_mem_sys_chk u_chk (.*);

// File: tb/page_mem_sys_tb.sv
module page_mem_sys_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        wr = 1'b0;
  logic [7:0]  wd = 8'h00;
  logic        remap_n = 1'b1;
  logic [7:0]  rdata;
  logic        s_rom0, s_rom1, s_ram, s_disp, msel;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] ref_ram [1024];
  logic [7:0] exp_rd = 8'h00;
  string      rd_tag = "R11";
  string      phase_tag = "";

  always #2.5 clk = ~clk;

  page_mem_sys u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wd),
    .remap_ni(remap_n), .rdata_o(rdata), .rom0_sel_no(s_rom0),
    .rom1_sel_no(s_rom1), .ram_sel_no(s_ram), .disp_sel_no(s_disp),
    .mem_sel_o(msel)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (addr 0x%04h remap_n %0b)",
               tag, act, exp, addr, remap_n);
    end
  endtask

  // 0 none, 1 rom0, 2 rom1, 3 ram, 4 disp
  function automatic int exp_page(logic [15:0] a, logic rn);
    if (!rn) return (a[15:10] == 6'd0) ? 1 : 0;
    if (a[15:12] != 4'hC) return 0;
    return 1 + int'(a[11:10]);
  endfunction

  function automatic logic [7:0] rom_val(int i);
    return 8'(((i % 256) * 3) % 256) ^ 8'(((i / 256) % 8) * 32);
  endfunction

  function automatic string sel_tag(logic [15:0] a, logic rn);
    if (!rn) return "R7";
    if (a[15:10] == 6'd0) return "R8";
    if (a[15:12] != 4'hC) return "R2";
    return "R1";
  endfunction

  task automatic check_now();
    int pg;
    logic [3:0] exp_n;
    pg = exp_page(addr, remap_n);
    exp_n = 4'hF;
    if (pg != 0) exp_n[4-pg] = 1'b0;
    chk(sel_tag(addr, remap_n), {s_rom0, s_rom1, s_ram, s_disp}, exp_n);
    chk("R3", $countones(~{s_rom0, s_rom1, s_ram, s_disp}) <= 1, 1);
    chk("R4", msel, pg != 0);
    chk(phase_tag != "" ? phase_tag : rd_tag, rdata, exp_rd);
  endtask

  // check present cycle, then apply new inputs and predict next rdata
  task automatic step(logic [15:0] a, logic w, logic [7:0] d, logic rn);
    int pg;
    @(negedge clk);
    check_now();
    addr = a; wr = w; wd = d; remap_n = rn;
    pg = exp_page(a, rn);
    case (pg)
      1: begin exp_rd = rom_val(int'(a[9:0])); rd_tag = "R10"; end
      2: begin exp_rd = rom_val(1024 + int'(a[9:0])); rd_tag = "R10"; end
      3: begin exp_rd = ref_ram[a[9:0]]; rd_tag = "R5"; end
      default: begin exp_rd = 8'h00; rd_tag = "R9"; end
    endcase
    if (pg == 3 && w) ref_ram[a[9:0]] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) ref_ram[i] = 8'h00;
    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", rdata, 8'h00);
    rst_n = 1'b1;
    // clear RAM so the model is defined
    for (int i = 0; i < 1024; i++) step(16'hC800 + 16'(i), 1'b1, 8'h00, 1'b1);
    // R5: write/read RAM, boundaries and read-first
    step(16'hC800, 1'b1, 8'h11, 1'b1);
    step(16'hCBFF, 1'b1, 8'hEE, 1'b1);
    step(16'hC800, 1'b0, 8'h00, 1'b1);
    step(16'hCBFF, 1'b0, 8'h00, 1'b1);
    step(16'hC955, 1'b1, 8'h5A, 1'b1);
    step(16'hC955, 1'b1, 8'hA5, 1'b1);
    step(16'hC955, 1'b0, 8'h00, 1'b1);
    // R10: ROM pages
    step(16'hC000, 1'b0, 8'h00, 1'b1);
    step(16'hC3FF, 1'b0, 8'h00, 1'b1);
    step(16'hC400, 1'b0, 8'h00, 1'b1);
    step(16'hC7FF, 1'b0, 8'h00, 1'b1);
    // R6: writes to ROM/display/unselected have no effect
    phase_tag = "R6";
    step(16'hC123, 1'b1, 8'hFF, 1'b1);
    step(16'hC523, 1'b1, 8'hFF, 1'b1);
    step(16'hCC55, 1'b1, 8'h77, 1'b1);
    step(16'h4955, 1'b1, 8'h77, 1'b1);
    step(16'hC855, 1'b1, 8'h77, 1'b0);
    step(16'h0155, 1'b1, 8'h77, 1'b0);
    step(16'hC123, 1'b0, 8'h00, 1'b1);
    step(16'hC523, 1'b0, 8'h00, 1'b1);
    step(16'hC955, 1'b0, 8'h00, 1'b1);
    step(16'hC855, 1'b0, 8'h00, 1'b1);
    phase_tag = "";
    // R9/R2: display and outside pages
    step(16'hCC00, 1'b0, 8'h00, 1'b1);
    step(16'hD800, 1'b0, 8'h00, 1'b1);
    step(16'h8000, 1'b0, 8'h00, 1'b1);
    // R7: remap low page and suppressed C region
    step(16'h0000, 1'b0, 8'h00, 1'b0);
    step(16'h03FF, 1'b0, 8'h00, 1'b0);
    step(16'h0400, 1'b0, 8'h00, 1'b0);
    step(16'hC000, 1'b0, 8'h00, 1'b0);
    step(16'hCFFF, 1'b0, 8'h00, 1'b0);
    // R8: low page without remap
    step(16'h0000, 1'b0, 8'h00, 1'b1);
    step(16'h02AA, 1'b0, 8'h00, 1'b1);
    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = 16'($urandom);
      if (sel < 5) a[15:12] = 4'hC;
      else if (sel < 7) a[15:10] = 6'd0;
      step(a, $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 3) != 0);
    end
    step(16'h0000, 1'b0, 8'h00, 1'b1);
    @(negedge clk);
    check_now();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule